// File: doc/BRIEF.md
# Matrix Keypad Scanner with Scan-Result FIFO

The block sweeps a keyboard matrix of up to 16 driven rows and 8 sensed columns. While it waits for a press, it drives every row high and watches for any column that goes high. When a column goes high, it waits a programmable hold-off. It then sweeps the rows one at a time in ascending order. Each row is held for a fixed base time plus a programmable debounce time. A key counts as pressed only when its column has been steady high through the debounce window at the end of the row slot.

Every sweep that finds keys stores one result of up to eight one-byte entries in a small FIFO. After each sweep the block waits a programmable gap and sweeps again, for as long as any key stays down. The first sweep that finds no keys sends the block back to waiting for a press.

Software sees a simple register port. It holds control and threshold fields, a sticky status bit with the FIFO count, the hold-off and gap counts, two read windows onto the oldest stored result, and one wake mask per row. The interrupt output is level-high. It is asserted while the FIFO count has reached the programmed threshold and the interrupt enable is set. The wake output pulses whenever a row slot finds a key in a row that is not masked.

Top module: `kmx_scanner`

## Requirements
- R1: After reset, `row_drive`, `irq` and `wake` are low, and the control register (0x00) and status register (0x04) read 0.
- R2: When enabled (control bit 0) and waiting, all rows are driven high, and any high column starts a scan. When the enable is clear, rows are driven low and no results are stored.
- R3: During a sweep exactly one row is driven, in ascending order. Each row is held for 16 + D cycles, where D is the debounce field at control bits 13:4.
- R4: Between two consecutive sweeps, all rows are low for exactly G + 5 cycles, where G is the gap register (0x0C). The hold-off register (0x08) sets the wait from the first detected press to the first sweep.
- R5: A key is recorded only if its column is high on each of the last D + 1 cycles of its row slot. A contact that toggles every cycle is never recorded when D ≥ 1.
- R6: A result packs up to eight bytes {1'b1, row[3:0], col[2:0]}, ordered by row and then by column, with unused bytes 0. Bytes 0–3 read at 0x10 and bytes 4–7 read at 0x14, each little-endian. An empty FIFO reads 0.
- R7: A read of 0x14 removes the oldest result. The status register reports the FIFO count in bits 7:4.
- R8: When the FIFO is full, new results are dropped, and the count and the stored results stay as they were.
- R9: A sweep that finds no key stores nothing and returns the block to waiting, with all rows driven.
- R10: Status bit 2 is set whenever the threshold T (control bits 17:14) is nonzero and count ≥ T. Writing 1 to bit 2 clears it. `irq` is high when bit 2 and the interrupt enable (control bit 3) are both set.
- R11: Each row has a mask register at 0x20 + 4·row. It stores "masked" when written with all ones and reads back as all ones or 0, and any other value written reads back as 0. `wake` pulses when a row slot records a key in an unmasked row.
- R12: The control register reads back its enable, interrupt enable, 10-bit debounce field and 4-bit threshold field, so the debounce value is limited to 0x3FF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan and register clock |
| rst | input | 1 | Synchronous active-high reset |
| row_drive | output | ROWS | Row strobes, active high |
| col_sense | input | COLS | Column returns, high when a key in a driven row is closed |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_re` |
| irq | output | 1 | Level-high FIFO threshold interrupt |
| wake | output | 1 | One-cycle pulse on a key found in an unmasked row |

## Verification
The hardest state to reach is a full FIFO with dropped sweeps and the status bit re-setting after a clear. The bench reaches it by holding a key down until four results are stored, then waiting through many more sweeps, then releasing the key so polling stops. It then raises the threshold and alternates pops with write-one clears, so the status bit is seen to re-set while the count stays at or above the threshold and to stay cleared once the count drops below it. Debounce rejection uses a modelled contact that toggles every cycle next to a steady one in the same row.

// File: rtl/kmx_pkg.sv
package kmx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_WAIT, ST_SWEEP} scan_st_t;

  // entries per stored scan result (fixed by the two 32-bit read windows)
  localparam int SLOTS = 8;

  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_STAT  = 8'h04;
  localparam logic [7:0] A_HOLD  = 8'h08;
  localparam logic [7:0] A_GAP   = 8'h0C;
  localparam logic [7:0] A_ENTLO = 8'h10;
  localparam logic [7:0] A_ENTHI = 8'h14;
  localparam logic [7:0] A_MASK0 = 8'h20;

  localparam int CTL_EN      = 0;
  localparam int CTL_IE      = 3;
  localparam int CTL_DEB_LSB = 4;
  localparam int CTL_THR_LSB = 14;
  localparam int STAT_HIT    = 2;
  localparam int STAT_CNT_LSB = 4;
endpackage

// File: rtl/kmx_fifo.sv
module kmx_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;

  wire is_full  = (count == CW'(DEPTH));
  wire is_empty = (count == '0);
  wire do_push  = push && !is_full;
  wire do_pop   = pop && !is_empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  assign head = is_empty ? '0 : mem[rp];

  // R8: a push into a full FIFO leaves the count unchanged
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (is_full && push && !pop) |=> (count == CW'(DEPTH)));
  // R7: a pop from an empty FIFO leaves it empty
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (is_empty && pop && !push) |=> (count == '0));
endmodule

// File: rtl/kmx_scan.sv
module kmx_scan
  import kmx_pkg::*;
#(
  parameter int ROWS     = 16,
  parameter int COLS     = 8,
  parameter int ROW_BASE = 16,
  parameter int LEAD     = 5,
  parameter int DEB_W    = 10,
  parameter int HOLD_W   = 20,
  parameter int GAP_W    = 20,
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int NW    = $clog2(SLOTS + 1),
  localparam int BIG   = (HOLD_W > GAP_W) ? HOLD_W : GAP_W,
  localparam int CNT_W = ((BIG > DEB_W + 5) ? BIG : DEB_W + 5) + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [DEB_W-1:0]   deb,
  input  logic [HOLD_W-1:0]  hold_cyc,
  input  logic [GAP_W-1:0]   gap_cyc,
  input  logic [ROWS-1:0]    row_mask,
  input  logic [COLS-1:0]    col_sense,
  output logic [ROWS-1:0]    row_drive,
  output logic               push,
  output logic [SLOTS*8-1:0] push_data,
  output logic               wake
);
  scan_st_t           st;
  logic [RW-1:0]      row;
  logic [CNT_W-1:0]   cnt;
  logic [COLS-1:0]    acc;
  logic [SLOTS*8-1:0] buf_q, buf_d;
  logic [NW-1:0]      n_q, n_d;

  wire [CNT_W-1:0] slot_len = CNT_W'(ROW_BASE - 1) + CNT_W'(deb);
  wire [COLS-1:0]  hits     = (deb == '0) ? col_sense : (acc & col_sense);
  wire             last_row = (row == RW'(ROWS - 1));

  // append the keys found in this slot, lowest column first
  always_comb begin
    buf_d = buf_q;
    n_d   = n_q;
    for (int c = 0; c < COLS; c++) begin
      if (hits[c] && (n_d < NW'(SLOTS))) begin
        buf_d[int'(n_d)*8 +: 8] = {1'b1, 4'(row), 3'(c)};
        n_d = n_d + 1'b1;
      end
    end
  end

  always_comb begin
    row_drive = '0;
    if (st == ST_IDLE && en) row_drive = '1;
    else if (st == ST_SWEEP) row_drive[row] = 1'b1;
  end

  always_ff @(posedge clk) begin
    push <= 1'b0;
    wake <= 1'b0;
    if (rst || !en) begin
      st        <= ST_IDLE;
      row       <= '0;
      cnt       <= '0;
      acc       <= '0;
      buf_q     <= '0;
      n_q       <= '0;
      push_data <= '0;
    end else begin
      acc <= (cnt == CNT_W'(deb)) ? col_sense : (acc & col_sense);
      case (st)
        ST_IDLE: begin
          if (|col_sense) begin
            st  <= ST_HOLD;
            cnt <= CNT_W'(hold_cyc);
          end
        end
        ST_HOLD: begin
          if (cnt == '0) begin
            st  <= ST_WAIT;
            cnt <= CNT_W'(LEAD - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            st    <= ST_SWEEP;
            row   <= '0;
            cnt   <= slot_len;
            buf_q <= '0;
            n_q   <= '0;
          end else cnt <= cnt - 1'b1;
        end
        default: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            buf_q <= buf_d;
            n_q   <= n_d;
            if (|hits && !row_mask[row]) wake <= 1'b1;
            if (last_row) begin
              if (n_d != '0) begin
                push      <= 1'b1;
                push_data <= buf_d;
                st        <= ST_WAIT;
                cnt       <= CNT_W'(gap_cyc) + CNT_W'(LEAD - 1);
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              row <= row + 1'b1;
              cnt <= slot_len;
            end
          end
        end
      endcase
    end
  end

  // R3: rows advance by one within a sweep
  a_r3_row_ascends: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SWEEP && $past(st == ST_SWEEP) && row != $past(row)) |-> (row == $past(row) + 1'b1));
  // R6: every stored result starts with a valid byte
  a_r6_push_valid: assert property (@(posedge clk) disable iff (rst)
    push |-> push_data[7]);
  // R11: wake only follows a row slot
  a_r11_wake_in_sweep: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(st == ST_SWEEP));
  // R2: a disabled scanner drives no row
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!en -> (row_drive == '0)));
endmodule

// File: rtl/kmx_regs.sv
module kmx_regs
  import kmx_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int DEB_W  = 10,
  parameter int THR_W  = 4,
  parameter int HOLD_W = 20,
  parameter int GAP_W  = 20,
  parameter int CW     = 3,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic               re,
  input  logic [7:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [SLOTS*8-1:0] head,
  input  logic [CW-1:0]      count,
  output logic               pop,
  output logic               en,
  output logic [DEB_W-1:0]   deb,
  output logic [HOLD_W-1:0]  hold_cyc,
  output logic [GAP_W-1:0]   gap_cyc,
  output logic [ROWS-1:0]    row_mask,
  output logic               irq
);
  logic             ie;
  logic [THR_W-1:0] thr;
  logic             hit;

  wire sel_mask = (int'(addr) >= int'(A_MASK0)) &&
                  (int'(addr) < int'(A_MASK0) + 4 * ROWS) && (addr[1:0] == 2'b00);
  wire [RW-1:0] midx = RW'((int'(addr) - int'(A_MASK0)) / 4);
  wire hit_set = (thr != '0) && (32'(count) >= 32'(thr));
  wire hit_clr = we && (addr == A_STAT) && wdata[STAT_HIT];

  assign pop = re && (addr == A_ENTHI);

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      ie       <= 1'b0;
      deb      <= '0;
      thr      <= '0;
      hold_cyc <= '0;
      gap_cyc  <= '0;
      row_mask <= '0;
      hit      <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (we) begin
        if (addr == A_CTRL) begin
          en  <= wdata[CTL_EN];
          ie  <= wdata[CTL_IE];
          deb <= wdata[CTL_DEB_LSB +: DEB_W];
          thr <= wdata[CTL_THR_LSB +: THR_W];
        end
        if (addr == A_HOLD) hold_cyc <= wdata[HOLD_W-1:0];
        if (addr == A_GAP)  gap_cyc  <= wdata[GAP_W-1:0];
        if (sel_mask)       row_mask[midx] <= &wdata;
      end
      hit <= hit_set | (hit & ~hit_clr);
      irq <= hit & ie;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (re) begin
      rdata <= '0;
      if (addr == A_CTRL) begin
        rdata[CTL_EN] <= en;
        rdata[CTL_IE] <= ie;
        rdata[CTL_DEB_LSB +: DEB_W] <= deb;
        rdata[CTL_THR_LSB +: THR_W] <= thr;
      end
      if (addr == A_STAT) begin
        rdata[STAT_HIT] <= hit;
        rdata[STAT_CNT_LSB +: CW] <= count;
      end
      if (addr == A_HOLD)  rdata[HOLD_W-1:0] <= hold_cyc;
      if (addr == A_GAP)   rdata[GAP_W-1:0]  <= gap_cyc;
      if (addr == A_ENTLO) rdata <= head[0 +: 32];
      if (addr == A_ENTHI) rdata <= head[32 +: 32];
      if (sel_mask)        rdata <= {32{row_mask[midx]}};
    end
  end

  // R10: a write-one clear with no threshold leaves the status bit low
  a_r10_clear_holds: assert property (@(posedge clk) disable iff (rst)
    (hit_clr && thr == '0) |=> !hit);
  // R10: the interrupt needs its enable
  a_r10_irq_needs_ie: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ie));
endmodule

// File: rtl/kmx_scanner.sv
module kmx_scanner
  import kmx_pkg::*;
#(
  parameter int ROWS     = 16,
  parameter int COLS     = 8,
  parameter int DEPTH    = 4,
  parameter int ROW_BASE = 16,
  parameter int LEAD     = 5,
  parameter int DEB_W    = 10,
  parameter int THR_W    = 4,
  parameter int HOLD_W   = 20,
  parameter int GAP_W    = 20
) (
  input  logic            clk,
  input  logic            rst,
  output logic [ROWS-1:0] row_drive,
  input  logic [COLS-1:0] col_sense,
  input  logic            reg_we,
  input  logic            reg_re,
  input  logic [7:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            irq,
  output logic            wake
);
  localparam int CW = $clog2(DEPTH + 1);

  logic               en, push, pop;
  logic [DEB_W-1:0]   deb;
  logic [HOLD_W-1:0]  hold_cyc;
  logic [GAP_W-1:0]   gap_cyc;
  logic [ROWS-1:0]    row_mask;
  logic [SLOTS*8-1:0] push_data, head;
  logic [CW-1:0]      count;

  kmx_regs #(.ROWS(ROWS), .DEB_W(DEB_W), .THR_W(THR_W), .HOLD_W(HOLD_W),
             .GAP_W(GAP_W), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .re(reg_re), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .head(head), .count(count),
    .pop(pop), .en(en), .deb(deb), .hold_cyc(hold_cyc), .gap_cyc(gap_cyc),
    .row_mask(row_mask), .irq(irq));

  kmx_scan #(.ROWS(ROWS), .COLS(COLS), .ROW_BASE(ROW_BASE), .LEAD(LEAD),
             .DEB_W(DEB_W), .HOLD_W(HOLD_W), .GAP_W(GAP_W)) u_scan (
    .clk(clk), .rst(rst), .en(en), .deb(deb), .hold_cyc(hold_cyc),
    .gap_cyc(gap_cyc), .row_mask(row_mask), .col_sense(col_sense),
    .row_drive(row_drive), .push(push), .push_data(push_data), .wake(wake));

  kmx_fifo #(.WIDTH(SLOTS * 8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data), .pop(pop),
    .head(head), .count(count));
endmodule

// File: tb/kmx_scanner_bench.sv
module kmx_scanner_bench;
  localparam int ROWS = 16;
  localparam int COLS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [ROWS-1:0] row_drive;
  logic [COLS-1:0] col_sense;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq, wake;

  logic [COLS-1:0] keys   [ROWS];
  logic [COLS-1:0] bounce [ROWS];
  logic phase = 1'b0;
  int wake_cnt = 0;
  int n_chk = 0, n_bad = 0;

  always @(negedge clk) phase <= ~phase;
  always @(posedge clk) if (wake === 1'b1) wake_cnt <= wake_cnt + 1;

  always_comb begin
    col_sense = '0;
    for (int r = 0; r < ROWS; r++)
      if (row_drive[r]) col_sense = col_sense | keys[r] | (phase ? bounce[r] : '0);
  end

  kmx_scanner u_kmx_scanner (
    .clk(clk), .rst(rst), .row_drive(row_drive), .col_sense(col_sense),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .wake(wake));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic get_count(output int c);
    logic [31:0] s;
    rd(8'h04, s);
    c = int'(s[7:4]);
  endtask

  task automatic wait_count(input int want);
    int c;
    get_count(c);
    while (c < want) get_count(c);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (row_drive !== '1) @(negedge clk);
  endtask

  task automatic release_all();
    for (int r = 0; r < ROWS; r++) begin keys[r] = '0; bounce[r] = '0; end
  endtask

  task automatic flush();
    int c;
    logic [31:0] d;
    get_count(c);
    while (c != 0) begin rd(8'h14, d); get_count(c); end
  endtask

  function automatic logic [63:0] expect_entries();
    logic [63:0] v = '0;
    int n = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (keys[r][c] && n < 8) begin
          v[n*8 +: 8] = {1'b1, 4'(r), 3'(c)};
          n++;
        end
    return v;
  endfunction

  task automatic check_result(input string req, input logic [63:0] exp);
    logic [31:0] lo, hi;
    wait_count(1);
    rd(8'h10, lo);
    rd(8'h14, hi);
    chk(req, {hi, lo}, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int n, c, w0;
    void'($urandom(32'd4242));
    release_all();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rows", 64'(row_drive), 64'h0);
    chk("R1 irq", 64'(irq), 64'h0);
    chk("R1 wake", 64'(wake), 64'h0);
    rd(8'h00, d); chk("R1 ctrl", 64'(d), 64'h0);
    rd(8'h04, d); chk("R1 stat", 64'(d), 64'h0);

    // enable, ie, debounce 2, threshold 1; hold-off 3, gap 4
    wr(8'h00, 32'h0000_4029);
    wr(8'h08, 32'd3);
    wr(8'h0C, 32'd4);
    rd(8'h00, d); chk("R12 ctrl readback", 64'(d), 64'h4029);
    rd(8'h08, d); chk("R4 hold readback", 64'(d), 64'd3);
    repeat (3) @(negedge clk);
    chk("R2 idle drive", 64'(row_drive), 64'hFFFF);

    // single key, format and interrupt
    keys[3][5] = 1'b1;
    check_result("R6 single key", 64'h9D);
    repeat (2) @(negedge clk);
    chk("R10 irq at threshold", 64'(irq), 64'h1);

    // R3 slot length
    while (row_drive !== 16'h0) @(negedge clk);
    while (row_drive !== 16'h1) @(negedge clk);
    n = 0;
    while (row_drive === 16'h1) begin n++; @(negedge clk); end
    chk("R3 slot length", 64'(n), 64'd18);
    // R4 gap length
    while (row_drive !== 16'h8000) @(negedge clk);
    while (row_drive === 16'h8000) @(negedge clk);
    n = 0;
    while (row_drive === 16'h0) begin n++; @(negedge clk); end
    chk("R4 gap length", 64'(n), 64'd9);

    // R9 empty sweep returns to waiting and stores nothing
    release_all();
    wait_idle();
    flush();
    repeat (600) @(negedge clk);
    chk("R9 idle drive", 64'(row_drive), 64'hFFFF);
    get_count(c); chk("R9 nothing stored", 64'(c), 64'h0);

    // R5 debounce: a toggling contact is rejected
    keys[6][1] = 1'b1;
    bounce[6][4] = 1'b1;
    bounce[9][0] = 1'b1;
    check_result("R5 bounce rejected", 64'hB1);
    release_all(); wait_idle(); flush();

    // R6 more than eight keys: first eight in scan order
    keys[0] = 8'hFF;
    keys[1][2] = 1'b1;
    check_result("R6 eight-entry cap", 64'h8786_8584_8382_8180);
    release_all(); wait_idle(); flush();

    // R6 random patterns
    for (int it = 0; it < 6; it++) begin
      int nk;
      nk = 1 + int'($urandom % 11);
      for (int k = 0; k < nk; k++) keys[$urandom % ROWS][$urandom % COLS] = 1'b1;
      check_result("R6 random pattern", expect_entries());
      release_all(); wait_idle(); flush();
    end

    // R8 full FIFO drops further sweeps
    keys[2][0] = 1'b1;
    wait_count(4);
    repeat (1500) @(negedge clk);
    release_all(); wait_idle();
    get_count(c); chk("R8 count held at depth", 64'(c), 64'd4);

    // R10 interrupt gated by enable
    wr(8'h00, 32'h0000_4021);
    repeat (3) @(negedge clk);
    chk("R10 irq gated", 64'(irq), 64'h0);
    rd(8'h04, d); chk("R10 status set", 64'(d[2]), 64'h1);

    // R10 threshold 3 with clears between pops
    wr(8'h00, 32'h0000_C029);
    wr(8'h04, 32'h4);
    rd(8'h04, d); chk("R10 re-set at count 4", 64'(d[2]), 64'h1);
    rd(8'h10, d); chk("R8 oldest kept", 64'(d), 64'h90);
    rd(8'h14, d);
    wr(8'h04, 32'h7);
    rd(8'h04, d); chk("R7 count after pop", 64'(d[7:4]), 64'd3);
    chk("R10 re-set at count 3", 64'(d[2]), 64'h1);
    rd(8'h14, d);
    wr(8'h04, 32'h7);
    rd(8'h04, d); chk("R10 cleared below threshold", 64'(d), 64'h20);
    repeat (2) @(negedge clk);
    chk("R10 irq low below threshold", 64'(irq), 64'h0);
    rd(8'h14, d); rd(8'h14, d);
    rd(8'h10, d); chk("R6 empty reads zero", 64'(d), 64'h0);
    get_count(c); chk("R7 drained", 64'(c), 64'h0);

    // R11 wake masks
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, d); chk("R11 mask readback", 64'(d), 64'hFFFF_FFFF);
    wr(8'h34, 32'h5);
    rd(8'h34, d); chk("R11 partial mask reads zero", 64'(d), 64'h0);
    w0 = wake_cnt;
    keys[2][0] = 1'b1;
    wait_count(1);
    release_all(); wait_idle(); flush();
    chk("R11 masked row no wake", 64'(wake_cnt), 64'(w0));
    keys[5][3] = 1'b1;
    wait_count(1);
    release_all(); wait_idle(); flush();
    chk("R11 unmasked row wakes", 64'(wake_cnt > w0), 64'h1);

    // R2 disabled scanner
    wr(8'h00, 32'h0);
    @(negedge clk);
    chk("R2 disabled rows low", 64'(row_drive), 64'h0);
    keys[1][1] = 1'b1;
    repeat (1000) @(negedge clk);
    get_count(c); chk("R2 disabled stores nothing", 64'(c), 64'h0);
    release_all();

    // R12 field widths
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R12 debounce limited", 64'(d), 64'h3_FFF9);
    wr(8'h00, 32'h0);

    finish_run();
  end
endmodule